// File: doc/BRIEF.md
# Self-Clocked Serial Result Transmitter

This block is the output side of a serial port on a multichannel 12-bit acquisition device, used when the device owns the link. It makes its own serial clock by dividing the system clock, drives an active-low frame strobe, and sends one 16-bit word each time a conversion finishes. The word starts with a zero bit. The 3-bit channel address follows, then the 12-bit result, most significant bit first. A host serial port that accepts an external clock captures each bit on the falling edge of the serial clock.

The address and result are captured in a shift register on the cycle that conversion-done is accepted. The inputs may change freely after that point. While a frame is in progress, further conversion-done pulses are dropped. When the external-clock select input is high, the block does not start frames. The data-output enable stands in for a three-state driver; when it is low the data line is held at zero.

Top module: `ser_result_tx`

## Requirements
- R1: Synchronous active-high reset puts the block in idle. In idle `frame_n` is 1, `sdo_oe` is 0, `busy` is 0 and `sclk` is 1.
- R2: When `conv_done` is high at a clock edge, the block is idle and `ext_clk_sel` is 0, the outputs after that edge are `frame_n` = 0, `sdo_oe` = 1 and `busy` = 1.
- R3: Within a frame, each serial bit period is `DIV` system clocks. `sclk` is 1 for the first `DIV/2` clocks of the period and 0 for the rest. Between frames `sclk` stays at 1.
- R4: The frame is 16 bits sent in this order: a 0, then `chan_addr[2:0]` MSB first, then `conv_result[11:0]` MSB first. Bit k is on `sdo` for system clocks k·DIV through (k+1)·DIV−1, counted from the start edge.
- R5: While `sdo_oe` stays high, `sdo` changes only on clocks where `sclk` rises.
- R6: `frame_n` stays low for exactly 16·DIV system clocks. On the 16th rising edge of `sclk`, `frame_n` goes to 1 and `sdo_oe` goes to 0 together.
- R7: The transmitted word holds the `chan_addr` and `conv_result` values present at the start edge. Later changes to those inputs do not affect it.
- R8: A `conv_done` pulse that arrives while `busy` is 1 neither starts nor restarts a frame. The frame in progress finishes unchanged.
- R9: While `ext_clk_sel` is 1, `conv_done` is ignored and the block stays idle.
- R10: While `sdo_oe` is 0, `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk_sel | input | 1 | 0 = block masters the link; 1 = frames are not started |
| conv_done | input | 1 | One-clock pulse marking the end of a conversion |
| chan_addr | input | ADDR_W (3) | Channel address from the control register |
| conv_result | input | RES_W (12) | Conversion result |
| sclk | output | 1 | Generated serial clock, idles high |
| frame_n | output | 1 | Active-low frame strobe |
| sdo | output | 1 | Serial data, changes on the rising edge of `sclk` |
| sdo_oe | output | 1 | Data driver enable (three-state model) |
| busy | output | 1 | High from frame start until the data output is released |

## Verification
The assertions assume that `conv_done`, `ext_clk_sel` and the data inputs are synchronous to `clk`. They also assume reset is held for at least one edge before any property is evaluated, so that `$past` and `$rose` only see reset-defined values. The bench drives every input half a period away from the active edge. It applies reset before any stimulus and keeps `conv_done` to single-clock pulses. Pulses that land in a busy frame, or that arrive while the external-clock select is high, are deliberate. The scoreboard expects no frame from them.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } tx_state_e;

endpackage

// File: rtl/ser_tx_clkgen.sv
// Serial clock generator: phase counter over one bit period.
module ser_tx_clkgen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic active,
    output logic sclk,
    output logic rise_tick
);
    localparam int HALF = DIV / 2;
    localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [PW-1:0] phase;
        logic          sclk;
    } clk_regs_t;

    clk_regs_t cg_d, cg_q;

    // The last phase of a bit period is followed by a rising edge.
    assign rise_tick = active && (cg_q.phase == PW'(DIV - 1));

    always_comb begin
        cg_d = cg_q;
        if (start) begin
            cg_d.phase = '0;
        end else if (active) begin
            cg_d.phase = (cg_q.phase == PW'(DIV - 1)) ? '0 : cg_q.phase + 1'b1;
        end else begin
            cg_d.phase = '0;
        end
        // High half first, so sclk stays high across the start edge.
        cg_d.sclk = (cg_d.phase < PW'(HALF));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cg_q.phase <= '0;
            cg_q.sclk  <= 1'b1;
        end else begin
            cg_q <= cg_d;
        end
    end

    assign sclk = cg_q.sclk;
endmodule

// File: rtl/ser_tx_shreg.sv
// Frame word shift register: loaded on start, shifted on each rising sclk.
module ser_tx_shreg #(
    parameter int ADDR_W = 3,
    parameter int RES_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [ADDR_W-1:0] addr,
    input  logic [RES_W-1:0]  result,
    output logic              msb
);
    localparam int FW = 1 + ADDR_W + RES_W;

    logic [FW-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (load) begin
            word_d = {1'b0, addr, result};
        end else if (shift) begin
            word_d = {word_q[FW-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign msb = word_q[FW-1];
endmodule

// File: rtl/ser_tx_seq.sv
// Frame sequencer: accepts starts, counts rising edges, ends the frame.
module ser_tx_seq
    import ser_tx_pkg::*;
#(
    parameter int FRAME_BITS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic conv_done,
    input  logic ext_clk_sel,
    input  logic rise_tick,
    output logic load,
    output logic active,
    output logic frame_n,
    output logic oe,
    output logic busy
);
    localparam int BW = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1;

    typedef struct packed {
        tx_state_e     state;
        logic [BW-1:0] bit_cnt;
        logic          frame_n;
        logic          oe;
    } seq_regs_t;

    seq_regs_t sq_d, sq_q;
    logic      last_bit;

    assign load     = (sq_q.state == ST_IDLE) && conv_done && !ext_clk_sel;
    assign last_bit = (sq_q.bit_cnt == BW'(FRAME_BITS - 1));

    always_comb begin
        sq_d = sq_q;
        unique case (sq_q.state)
            ST_IDLE: begin
                if (load) begin
                    sq_d.state   = ST_SHIFT;
                    sq_d.bit_cnt = '0;
                    sq_d.frame_n = 1'b0;
                    sq_d.oe      = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (rise_tick) begin
                    if (last_bit) begin
                        sq_d.state   = ST_IDLE;
                        sq_d.bit_cnt = '0;
                        sq_d.frame_n = 1'b1;
                        sq_d.oe      = 1'b0;
                    end else begin
                        sq_d.bit_cnt = sq_q.bit_cnt + 1'b1;
                    end
                end
            end
            default: sq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sq_q.state   <= ST_IDLE;
            sq_q.bit_cnt <= '0;
            sq_q.frame_n <= 1'b1;
            sq_q.oe      <= 1'b0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign active  = (sq_q.state == ST_SHIFT);
    assign busy    = active;
    assign frame_n = sq_q.frame_n;
    assign oe      = sq_q.oe;
endmodule

// File: rtl/ser_result_tx.sv
// Top: self-clocked serial result transmitter.
module ser_result_tx #(
    parameter int DIV    = 4,
    parameter int ADDR_W = 3,
    parameter int RES_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_clk_sel,
    input  logic              conv_done,
    input  logic [ADDR_W-1:0] chan_addr,
    input  logic [RES_W-1:0]  conv_result,
    output logic              sclk,
    output logic              frame_n,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              busy
);
    localparam int FRAME_BITS = 1 + ADDR_W + RES_W;

    logic load, active, rise_tick, word_msb;

    ser_tx_seq #(.FRAME_BITS(FRAME_BITS)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .conv_done   (conv_done),
        .ext_clk_sel (ext_clk_sel),
        .rise_tick   (rise_tick),
        .load        (load),
        .active      (active),
        .frame_n     (frame_n),
        .oe          (sdo_oe),
        .busy        (busy)
    );

    ser_tx_clkgen #(.DIV(DIV)) u_clkgen (
        .clk       (clk),
        .rst       (rst),
        .start     (load),
        .active    (active),
        .sclk      (sclk),
        .rise_tick (rise_tick)
    );

    ser_tx_shreg #(.ADDR_W(ADDR_W), .RES_W(RES_W)) u_shreg (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .shift  (rise_tick),
        .addr   (chan_addr),
        .result (conv_result),
        .msb    (word_msb)
    );

    // Released driver modelled as a quiet zero.
    assign sdo = sdo_oe ? word_msb : 1'b0;
endmodule

// File: rtl/ser_result_tx_chk.sv
module ser_result_tx_chk #(
    parameter int DIV        = 4,
    parameter int FRAME_BITS = 16
) (
    input logic clk,
    input logic rst,
    input logic ext_clk_sel,
    input logic conv_done,
    input logic sclk,
    input logic frame_n,
    input logic sdo,
    input logic sdo_oe,
    input logic busy
);
    localparam int LEN = FRAME_BITS * DIV;
    localparam int CW  = $clog2(LEN + 1) + 1;

    logic [CW-1:0] low_cnt_q;

    always_ff @(posedge clk) begin
        if (rst || frame_n) low_cnt_q <= '0;
        else                low_cnt_q <= low_cnt_q + 1'b1;
    end

    assert_idle_state_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk && frame_n && !sdo_oe));

    assert_start_R2: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !busy && !ext_clk_sel) |=> (!frame_n && sdo_oe && busy && !sdo));

    assert_data_on_rise_R5: assert property (@(posedge clk) disable iff (rst)
        (sdo_oe && $past(sdo_oe) && !$rose(sclk)) |-> $stable(sdo));

    assert_frame_len_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_n) |-> (low_cnt_q == CW'(LEN)));

    assert_strobe_oe_pair_R6: assert property (@(posedge clk) disable iff (rst)
        frame_n == !sdo_oe);

    assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(frame_n) |-> !$past(busy));

    assert_ext_mode_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !busy && ext_clk_sel) |=> (!busy && frame_n));

    assert_quiet_line_R10: assert property (@(posedge clk) disable iff (rst)
        !sdo_oe |-> !sdo);
endmodule

bind ser_result_tx ser_result_tx_chk #(
    .DIV        (DIV),
    .FRAME_BITS (1 + ADDR_W + RES_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ext_clk_sel (ext_clk_sel),
    .conv_done   (conv_done),
    .sclk        (sclk),
    .frame_n     (frame_n),
    .sdo         (sdo),
    .sdo_oe      (sdo_oe),
    .busy        (busy)
);

// File: tb/tb_ser_result_tx.sv
module tb_ser_result_tx;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int FBITS      = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_clk_sel = 1'b0;
    logic        conv_done = 1'b0;
    logic [2:0]  chan_addr = '0;
    logic [11:0] conv_result = '0;
    logic        sclk, frame_n, sdo, sdo_oe, busy;

    int checks = 0;
    int failures = 0;
    int frames = 0;
    logic [15:0] exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ser_result_tx #(.DIV(DIV), .ADDR_W(3), .RES_W(12)) dut (
        .clk (clk), .rst (rst), .ext_clk_sel (ext_clk_sel),
        .conv_done (conv_done), .chan_addr (chan_addr),
        .conv_result (conv_result), .sclk (sclk), .frame_n (frame_n),
        .sdo (sdo), .sdo_oe (sdo_oe), .busy (busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: collects bits on falling sclk, scores each finished frame.
    logic        prev_sclk = 1'b1, prev_fn = 1'b1;
    logic [15:0] word = '0;
    int bits = 0, rises = 0, len = 0, cyc = 0, last_fall = 0;

    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (prev_fn && !frame_n) begin
                frames++;
                bits = 0; rises = 0; len = 0; word = '0;
                check(exp_q.size() != 0, "R8 frame with nothing queued", 1, 0);
            end
            if (!frame_n) len++;
            if (!prev_fn && !prev_sclk && sclk) rises++;
            if (sdo_oe && prev_sclk && !sclk) begin
                word = {word[14:0], sdo};
                bits++;
                if (bits > 1) check(cyc - last_fall == DIV, "R3 sclk period", cyc - last_fall, DIV);
                last_fall = cyc;
            end
            if (!prev_fn && frame_n) begin
                check(bits == FBITS, "R4 bit count", bits, FBITS);
                check(rises == FBITS, "R6 end on 16th rise", rises, FBITS);
                check(len == FBITS * DIV, "R6 strobe length", len, FBITS * DIV);
                check(!sdo_oe && sclk, "R6 release/R3 idle high", {sdo_oe, sclk}, 2'b01);
                if (exp_q.size() != 0) begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check(word == e, "R4/R7 frame word", word, e);
                end
            end
            prev_sclk = sclk;
            prev_fn   = frame_n;
        end
    end

    task automatic send(input logic [2:0] a, input logic [11:0] r, input bit scramble);
        while (busy) @(negedge clk);
        conv_done   = 1'b1;
        chan_addr   = a;
        conv_result = r;
        exp_q.push_back({1'b0, a, r});
        @(negedge clk);
        conv_done = 1'b0;
        check(!frame_n && busy && sdo_oe, "R2 start", {frame_n, busy, sdo_oe}, 3'b011);
        check(sdo == 1'b0 && sclk, "R4 leading zero", {sdo, sclk}, 2'b01);
        if (scramble) begin
            chan_addr   = ~a;
            conv_result = ~r;
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(frame_n && !sdo_oe && sclk && !busy, "R1 reset idle",
              {frame_n, sdo_oe, sclk, busy}, 4'b1010);
        check(!sdo, "R10 quiet after reset", sdo, 0);

        send(3'd0, 12'h000, 1'b0);
        send(3'd7, 12'hFFF, 1'b0);   // R7 back-to-back, no gap
        send(3'd5, 12'hA5A, 1'b1);   // R7 inputs change mid-frame
        send(3'd2, 12'h123, 1'b1);
        wait_idle();
        check(exp_q.size() == 0, "R4 all frames scored", exp_q.size(), 0);

        // R8: a pulse inside a frame is dropped
        send(3'd6, 12'h801, 1'b0);
        repeat (20) @(negedge clk);
        conv_done = 1'b1; chan_addr = 3'd1; conv_result = 12'h7FE;
        @(negedge clk);
        conv_done = 1'b0;
        check(busy && !frame_n, "R8 frame continues", {busy, frame_n}, 2'b10);
        wait_idle();
        check(frames == 5, "R8 frame count", frames, 5);
        check(exp_q.size() == 0, "R8 no extra word", exp_q.size(), 0);

        // R9: external clock select blocks starts
        ext_clk_sel = 1'b1;
        conv_done = 1'b1; chan_addr = 3'd3; conv_result = 12'h3C3;
        @(negedge clk);
        conv_done = 1'b0;
        check(frame_n && !busy, "R9 stays idle", {frame_n, busy}, 2'b10);
        repeat (10 * DIV) @(negedge clk);
        check(frames == 5, "R9 no frame", frames, 5);
        check(!sdo && !sdo_oe && sclk, "R10 quiet line", {sdo, sdo_oe, sclk}, 3'b001);
        ext_clk_sel = 1'b0;

        send(3'd4, 12'h5A5, 1'b1);
        wait_idle();
        check(exp_q.size() == 0 && frames == 6, "R2 final frame", frames, 6);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R2 actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule